// File: doc/BRIEF.md
# E1 Dual-Rail Line Decoder with Violation Counting

This block turns the two receive rails of a 2.048 Mbit/s E1 line into one NRZ data stream. It works on the clock recovered from the line. A positive pulse appears as `rx_pos` high and a negative pulse as `rx_neg` high. The line code is chosen at run time: AMI, HDB3, or an NRZ bypass for data that has already been decoded upstream. The AMI and HDB3 decoders check the alternate-mark rule and flag each bit that breaks it with a one-cycle strobe. Every flagged bit also adds one to a 16-bit counter that stops at its maximum value. In HDB3 mode the zero substitutions are removed through a three-bit delay line. An optional extended check also flags long zero runs.

Polarity tracking is a small state machine, and the block runs two copies of it. The first copy follows the polarity of the last mark. The second copy follows the polarity of the last HDB3 substitution pulse. Each copy has three states: `PS_NONE` (no reference yet), `PS_POS` and `PS_NEG`. The copy moves to the state that matches each single-rail pulse it accepts. It stays where it is when both rails are high, when there is no pulse, or (for the second copy) on a pulse that is not a substitution pulse. It returns to `PS_NONE` whenever its mode is inactive. In this design the bypass mode is inactive for both copies, and the second copy is also inactive in AMI mode.

Top module: `e1_line_decoder`

## Requirements
- R1: `code_sel` selects the line code: 2'b00 is AMI, 2'b01 is HDB3, and both 2'b10 and 2'b11 select NRZ bypass.
- R2: In AMI and HDB3 modes, a bit sampled at rising edge k appears on `dout` after rising edge k+3. It reads 1 for a pulse on either rail and 0 for no pulse.
- R3: In AMI mode, a single-rail pulse with the same polarity as the previous pulse raises `viol` after the edge that samples it.
- R4: In HDB3 mode, the patterns 000V and B00V are decoded as four zeros. V is a pulse with the same polarity as the previous pulse.
- R5: In HDB3 mode, a V pulse with the same polarity as the previous V pulse raises `viol`. The first V after entering HDB3 mode is never flagged.
- R6: In HDB3 mode with `ext_det` = 1, the fourth consecutive bit without a pulse raises `viol` once per run. With `ext_det` = 0, zero runs are not flagged.
- R7: In AMI or HDB3 mode, both rails high in one bit gives exactly one violation and a decoded 1. It leaves the polarity reference unchanged.
- R8: In NRZ mode, `rx_pos` is sampled on the falling clock edge and appears on `dout` after the next rising edge. `rx_neg` is ignored, `viol` stays 0 and the counter does not change.
- R9: Each violation strobe adds one to `viol_count`, and the new count is visible after the same edge as the strobe.
- R10: `viol_count` stops at 16'hFFFF and does not wrap.
- R11: `cnt_clr` clears the counter at the next rising edge, and it takes priority over a violation in the same cycle.
- R12: After reset, `dout`, `viol` and `viol_count` are 0, and both polarity trackers are in `PS_NONE`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Recovered line clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_pos | input | 1 | Positive-pulse rail; carries the data bit in NRZ mode |
| rx_neg | input | 1 | Negative-pulse rail |
| code_sel | input | 2 | Line code select (R1) |
| ext_det | input | 1 | Enables zero-run checking in HDB3 mode |
| cnt_clr | input | 1 | Synchronous counter clear |
| dout | output | 1 | Decoded NRZ data |
| viol | output | 1 | One-cycle violation strobe |
| viol_count | output | 16 | Saturating violation count |

## Verification
The assertions assume that `code_sel`, `cnt_clr`, `rx_pos` and `rx_neg` are steady at each rising edge. They also assume that reset is released away from an edge. The stimulus meets these assumptions by changing inputs 5 ns after each rising edge. The only exception is an NRZ-only change made after the falling edge, which shows that the falling-edge sample is the one that is used. Before each mode change, every line-mode segment is padded with three pulse-free bits, so no decoded bit is left in the delay line. A bypass bit then drops both polarity trackers back to `PS_NONE`. The long saturation run drives both rails high in AMI mode, so every bit is a violation.

// File: rtl/e1_dec_pkg.sv
`timescale 1ns/1ps
package e1_dec_pkg;

    typedef enum logic [1:0] {
        LC_AMI     = 2'b00,
        LC_HDB3    = 2'b01,
        LC_NRZ     = 2'b10,
        LC_NRZ_ALT = 2'b11
    } line_code_e;

    typedef enum logic [1:0] {
        PS_NONE = 2'b00,
        PS_POS  = 2'b01,
        PS_NEG  = 2'b10
    } pol_state_e;

    function automatic logic code_is_line(input line_code_e c);
        return (c == LC_AMI) || (c == LC_HDB3);
    endfunction

endpackage

// File: rtl/e1_pol_tracker.sv
`timescale 1ns/1ps
module e1_pol_tracker
    import e1_dec_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    input  logic hdb3,
    input  logic pos,
    input  logic neg,
    output logic same_pol,
    output logic is_v,
    output logic vpol_err
);
    pol_state_e mark_st, mark_nx;
    pol_state_e v_st, v_nx;
    logic single;

    assign single = pos ^ neg;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mark_st <= PS_NONE;
            v_st    <= PS_NONE;
        end else begin
            mark_st <= mark_nx;
            v_st    <= v_nx;
        end
    end

    // outputs and next state
    always_comb begin
        same_pol = 1'b0;
        vpol_err = 1'b0;
        unique case (mark_st)
            PS_NONE: same_pol = 1'b0;
            PS_POS:  same_pol = single & pos;
            PS_NEG:  same_pol = single & neg;
            default: same_pol = 1'b0;
        endcase
        is_v = hdb3 & same_pol;
        unique case (v_st)
            PS_NONE: vpol_err = 1'b0;
            PS_POS:  vpol_err = is_v & pos;
            PS_NEG:  vpol_err = is_v & neg;
            default: vpol_err = 1'b0;
        endcase

        mark_nx = mark_st;
        if (!active)
            mark_nx = PS_NONE;
        else if (single)
            mark_nx = pos ? PS_POS : PS_NEG;

        v_nx = v_st;
        if (!(active && hdb3))
            v_nx = PS_NONE;
        else if (is_v)
            v_nx = pos ? PS_POS : PS_NEG;
    end
endmodule

// File: rtl/e1_sub_window.sv
`timescale 1ns/1ps
module e1_sub_window #(
    parameter int DEPTH = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic mark,
    input  logic wipe,
    output logic out_bit
);
    logic [DEPTH-1:0] line_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            line_q <= '0;
        else if (!en || wipe)
            line_q <= '0;
        else
            line_q <= {line_q[DEPTH-2:0], mark};
    end

    assign out_bit = en & ~wipe & line_q[DEPTH-1];
endmodule

// File: rtl/e1_zero_run.sv
`timescale 1ns/1ps
module e1_zero_run #(
    parameter int RUN_LEN = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic space,
    output logic hit
);
    localparam int CW = $clog2(RUN_LEN + 1);
    localparam logic [CW-1:0] TOP  = CW'(RUN_LEN);
    localparam logic [CW-1:0] LAST = CW'(RUN_LEN - 1);

    logic [CW-1:0] run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            run_q <= '0;
        else if (!en || !space)
            run_q <= '0;
        else if (run_q != TOP)
            run_q <= run_q + 1'b1;
    end

    assign hit = en & space & (run_q == LAST);
endmodule

// File: rtl/e1_sat_counter.sv
`timescale 1ns/1ps
module e1_sat_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] count
);
    localparam logic [W-1:0] MAXV = {W{1'b1}};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            count <= '0;
        else if (clr)
            count <= '0;
        else if (inc && count != MAXV)
            count <= count + 1'b1;
    end
endmodule

// File: rtl/e1_line_decoder.sv
`timescale 1ns/1ps
module e1_line_decoder
    import e1_dec_pkg::*;
#(
    parameter int CNT_W    = 16,
    parameter int SUB_SPAN = 3,
    parameter int ZRUN     = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_pos,
    input  logic             rx_neg,
    input  logic [1:0]       code_sel,
    input  logic             ext_det,
    input  logic             cnt_clr,
    output logic             dout,
    output logic             viol,
    output logic [CNT_W-1:0] viol_count
);
    line_code_e code;
    logic line_act, hdb3_act, ami_act;
    logic mark, both;
    logic same_pol, is_v, vpol_err;
    logic run_hit, win_bit, err;
    logic nrz_q, dout_q, viol_q;

    always_comb begin
        code     = line_code_e'(code_sel);
        line_act = code_is_line(code);
        hdb3_act = (code == LC_HDB3);
        ami_act  = (code == LC_AMI);
        mark     = rx_pos | rx_neg;
        both     = rx_pos & rx_neg;
    end

    e1_pol_tracker u_pol (
        .clk      (clk),
        .rst_n    (rst_n),
        .active   (line_act),
        .hdb3     (hdb3_act),
        .pos      (rx_pos),
        .neg      (rx_neg),
        .same_pol (same_pol),
        .is_v     (is_v),
        .vpol_err (vpol_err)
    );

    e1_sub_window #(.DEPTH(SUB_SPAN)) u_win (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (line_act),
        .mark    (mark),
        .wipe    (is_v),
        .out_bit (win_bit)
    );

    e1_zero_run #(.RUN_LEN(ZRUN)) u_zrun (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (line_act),
        .space (~mark),
        .hit   (run_hit)
    );

    always_comb begin
        err = line_act & (both
                          | (ami_act & same_pol)
                          | (hdb3_act & (vpol_err | (ext_det & run_hit))));
    end

    e1_sat_counter #(.W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (cnt_clr),
        .inc   (err),
        .count (viol_count)
    );

    // bypass data is taken on the falling edge
    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n)
            nrz_q <= 1'b0;
        else
            nrz_q <= rx_pos;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dout_q <= 1'b0;
            viol_q <= 1'b0;
        end else begin
            dout_q <= line_act ? win_bit : nrz_q;
            viol_q <= err;
        end
    end

    assign dout = dout_q;
    assign viol = viol_q;
endmodule

// File: rtl/e1_line_decoder_chk.sv
`timescale 1ns/1ps
module e1_line_decoder_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             rx_pos,
    input logic             rx_neg,
    input logic [1:0]       code_sel,
    input logic             cnt_clr,
    input logic             viol,
    input logic [CNT_W-1:0] viol_count
);
    localparam logic [CNT_W-1:0] MAXV = {CNT_W{1'b1}};

    a_r7_both_rails_flag: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(rx_pos && rx_neg && !code_sel[1])) |-> viol);

    a_r8_bypass_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(code_sel[1])) |-> !viol);

    a_r9_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(cnt_clr) && $past(viol_count) != MAXV)
        |-> viol_count == $past(viol_count) + CNT_W'(viol));

    a_r10_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(cnt_clr) && $past(viol_count) == MAXV)
        |-> viol_count == MAXV);

    a_r11_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(cnt_clr)) |-> viol_count == '0);
endmodule

bind e1_line_decoder e1_line_decoder_chk #(.CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rx_pos     (rx_pos),
    .rx_neg     (rx_neg),
    .code_sel   (code_sel),
    .cnt_clr    (cnt_clr),
    .viol       (viol),
    .viol_count (viol_count)
);

// File: tb/e1_line_decoder_test.sv
`timescale 1ns/1ps
module e1_line_decoder_test;
    localparam logic [1:0] AMI = 2'b00, HDB = 2'b01, NRZ = 2'b10, NRZ2 = 2'b11;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_pos = 1'b0, rx_neg = 1'b0;
    logic [1:0]  code_sel = NRZ;
    logic        ext_det = 1'b0;
    logic        cnt_clr = 1'b0;
    logic        dout, viol;
    logic [15:0] viol_count;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int model_cnt = 0;
    bit done = 0;

    typedef struct {
        int    due;
        bit    is_viol;
        logic  val;
        string tag;
    } item_t;
    item_t sb[$];

    e1_line_decoder uut (
        .clk(clk), .rst_n(rst_n), .rx_pos(rx_pos), .rx_neg(rx_neg),
        .code_sel(code_sel), .ext_det(ext_det), .cnt_clr(cnt_clr),
        .dout(dout), .viol(viol), .viol_count(viol_count)
    );

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // monitor: compare items due in this cycle
    always @(posedge clk) begin
        #15;
        for (int i = sb.size() - 1; i >= 0; i--) begin
            if (sb[i].due == cyc) begin
                if (sb[i].is_viol) begin
                    check(sb[i].tag, {31'b0, viol}, {31'b0, sb[i].val});
                    if (sb[i].val && model_cnt < 16'hFFFF) model_cnt++;
                    check({sb[i].tag, " R9 count"}, {16'b0, viol_count}, model_cnt);
                end else begin
                    check(sb[i].tag, {31'b0, dout}, {31'b0, sb[i].val});
                end
                sb.delete(i);
            end
        end
    end

    // driver: apply one bit and push its expected results
    task automatic send(input logic [1:0] m, input logic e, input logic p, input logic n,
                        input logic ed, input logic ev, input bit chk_d, input bit glitch,
                        input string tag);
        item_t it;
        @(posedge clk);
        #5;
        code_sel = m; ext_det = e; rx_pos = p; rx_neg = n;
        it.is_viol = 1'b1; it.val = ev; it.due = cyc + 1; it.tag = {tag, " viol"};
        sb.push_back(it);
        if (chk_d) begin
            it.is_viol = 1'b0; it.val = ed; it.due = cyc + (m[1] ? 1 : 4); it.tag = {tag, " dout"};
            sb.push_back(it);
        end
        if (glitch) begin
            #10;
            rx_pos = ~p;
        end
    endtask

    task automatic pad(input logic [1:0] m, input logic e);
        repeat (3) send(m, e, 0, 0, 0, 0, 0, 0, "pad R9");
        send(NRZ, 0, 0, 0, 0, 0, 1, 0, "R8 mode exit");
    endtask

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    initial begin
        #35 rst_n = 1'b1;
        #10;
        check("R12 reset dout", {31'b0, dout}, 0);
        check("R12 reset viol", {31'b0, viol}, 0);
        check("R12 reset count", {16'b0, viol_count}, 0);

        send(NRZ, 0, 0, 0, 0, 0, 1, 0, "R8 start");

        // AMI: R2, R3, R7
        send(AMI, 0, 1, 0, 1, 0, 1, 0, "R2 ami P");
        send(AMI, 0, 0, 1, 1, 0, 1, 0, "R2 ami N");
        send(AMI, 0, 0, 0, 0, 0, 1, 0, "R2 ami 0");
        send(AMI, 0, 1, 0, 1, 0, 1, 0, "R2 ami P2");
        send(AMI, 0, 0, 1, 1, 0, 1, 0, "R2 ami N2");
        send(AMI, 0, 1, 0, 1, 0, 1, 0, "R3 ami P3");
        send(AMI, 0, 0, 0, 0, 0, 1, 0, "R3 ami 0");
        send(AMI, 0, 1, 0, 1, 1, 1, 0, "R3 ami bpv");
        send(AMI, 0, 1, 1, 1, 1, 1, 0, "R7 both rails");
        send(AMI, 0, 0, 1, 1, 0, 1, 0, "R7 ref kept");
        send(AMI, 0, 0, 1, 1, 1, 1, 0, "R3 ami bpv neg");
        pad(AMI, 0);

        // HDB3 basic: R4, R5, R6 off
        send(HDB, 0, 1, 0, 1, 0, 1, 0, "R4 B");
        send(HDB, 0, 0, 0, 0, 0, 1, 0, "R4 000V 0");
        send(HDB, 0, 0, 0, 0, 0, 1, 0, "R4 000V 0");
        send(HDB, 0, 0, 0, 0, 0, 1, 0, "R4 000V 0");
        send(HDB, 0, 1, 0, 0, 0, 1, 0, "R5 first V");
        send(HDB, 0, 0, 1, 1, 0, 1, 0, "R4 mark N");
        send(HDB, 0, 0, 0, 0, 0, 1, 0, "R4 000V 0");
        send(HDB, 0, 0, 0, 0, 0, 1, 0, "R4 000V 0");
        send(HDB, 0, 0, 0, 0, 0, 1, 0, "R4 000V 0");
        send(HDB, 0, 0, 1, 0, 0, 1, 0, "R4 V neg");
        send(HDB, 0, 1, 0, 0, 0, 1, 0, "R4 B00V B");
        send(HDB, 0, 0, 0, 0, 0, 1, 0, "R4 B00V 0");
        send(HDB, 0, 0, 0, 0, 0, 1, 0, "R4 B00V 0");
        send(HDB, 0, 1, 0, 0, 0, 1, 0, "R4 B00V V");
        send(HDB, 0, 0, 1, 1, 0, 1, 0, "R4 mark N2");
        send(HDB, 0, 1, 0, 1, 0, 1, 0, "R4 mark P");
        send(HDB, 0, 0, 0, 0, 0, 1, 0, "R5 0");
        send(HDB, 0, 0, 0, 0, 0, 1, 0, "R5 0");
        send(HDB, 0, 0, 0, 0, 0, 1, 0, "R5 0");
        send(HDB, 0, 1, 0, 0, 1, 1, 0, "R5 V same pol");
        send(HDB, 0, 0, 0, 0, 0, 1, 0, "R6 off 0");
        send(HDB, 0, 0, 0, 0, 0, 1, 0, "R6 off 0");
        send(HDB, 0, 0, 0, 0, 0, 1, 0, "R6 off 0");
        send(HDB, 0, 0, 0, 0, 0, 1, 0, "R6 off 4th zero");
        send(HDB, 0, 0, 1, 1, 0, 1, 0, "R6 off mark");
        pad(HDB, 0);

        // HDB3 extended: R6
        send(HDB, 1, 0, 0, 0, 0, 1, 0, "R6 z1");
        send(HDB, 1, 0, 0, 0, 0, 1, 0, "R6 z2");
        send(HDB, 1, 0, 0, 0, 0, 1, 0, "R6 z3");
        send(HDB, 1, 0, 0, 0, 1, 1, 0, "R6 z4 flagged");
        send(HDB, 1, 0, 0, 0, 0, 1, 0, "R6 z5 once");
        send(HDB, 1, 1, 0, 1, 0, 1, 0, "R6 mark");
        send(HDB, 1, 0, 0, 0, 0, 1, 0, "R6 z1b");
        send(HDB, 1, 0, 0, 0, 0, 1, 0, "R6 z2b");
        send(HDB, 1, 0, 0, 0, 0, 1, 0, "R6 z3b");
        send(HDB, 1, 0, 0, 0, 1, 1, 0, "R6 z4b flagged");
        send(HDB, 1, 0, 1, 1, 0, 1, 0, "R6 mark N");
        pad(HDB, 1);

        // NRZ bypass: R8, R1
        send(NRZ, 0, 1, 1, 1, 0, 1, 0, "R8 nrz 1");
        send(NRZ, 0, 0, 1, 0, 0, 1, 1, "R8 falling edge 0");
        send(NRZ, 0, 1, 1, 1, 0, 1, 1, "R8 falling edge 1");
        send(NRZ, 0, 1, 0, 1, 0, 1, 0, "R8 nrz 1b");
        send(NRZ2, 0, 0, 1, 0, 0, 1, 0, "R1 code 11 bypass");
        send(NRZ2, 0, 1, 1, 1, 0, 1, 0, "R1 code 11 bypass 1");
        send(NRZ, 0, 0, 0, 0, 0, 1, 0, "R8 end");
        @(posedge clk);
        @(posedge clk);
        #5;
        check("R8 count unchanged", {16'b0, viol_count}, model_cnt);

        // saturation and clear: R10, R11
        cnt_clr = 1'b1;
        @(posedge clk);
        #5;
        cnt_clr = 1'b0;
        check("R11 clear", {16'b0, viol_count}, 0);
        code_sel = AMI; rx_pos = 1'b1; rx_neg = 1'b1;
        repeat (65537) @(posedge clk);
        #5;
        check("R10 saturate", {16'b0, viol_count}, 32'hFFFF);
        @(posedge clk);
        #5;
        check("R10 no wrap", {16'b0, viol_count}, 32'hFFFF);
        cnt_clr = 1'b1;
        @(posedge clk);
        #5;
        check("R11 clear beats error", {16'b0, viol_count}, 0);
        cnt_clr = 1'b0;
        @(posedge clk);
        #5;
        check("R11 count resumes", {16'b0, viol_count}, 1);
        code_sel = NRZ; rx_pos = 1'b0; rx_neg = 1'b0;
        repeat (3) @(posedge clk);
        #5;
        check("R8 quiet after", {31'b0, viol}, 0);

        done = 1;
        finish_run();
    end
endmodule